// File: doc/BRIEF.md
# Armed Actuator Pulse Controller

This block drives one timed pulse at a time onto a bank of actuator switch outputs. Software first loads a channel with a start second and a pulse length, then arms that channel, then issues a fire command. The pulse begins on the first 1/32 s tick at which a shared seconds count, supplied from outside, equals the loaded start second. The pulse then runs for the loaded length and disarms the channel when it ends.

Channel 0 is the long-duration channel and counts its length in quarter-second steps, up to 16 s. All other channels count in 1/32 s steps, up to 2 s. For a fixed period after reset every fire command is discarded, so no actuator can move during power-up. The short channels each return a discrete status line, and the block resynchronizes these lines for readback.

Only one channel may be pending or driving at any time. A fire command that arrives while a channel is busy is refused and latches an error flag, which stays set until software clears it.

Top module: `act_pulse_ctrl`

## Requirements
- R1: A fire command (`fire_we` with `fire_sel`) takes effect only on a channel whose `armed_o` bit is 1. Firing an unarmed channel produces no pulse and leaves `fire_err` at 0. `arm_we` with `arm_sel` sets the selected `armed_o` bit.
- R2: An accepted fire makes the channel wait. Its `act_out` bit rises on the first tick at which `sec_count` equals the channel's loaded start second. No pulse starts while the two values differ.
- R3: Channel 0 drives `act_out[0]` for (cfg_dur+1) x 8 ticks, which is (cfg_dur+1) quarter seconds. The longest pulse, at cfg_dur=63, is 16 s.
- R4: Every channel i >= 1 drives `act_out[i]` for (cfg_dur+1) ticks, which is (cfg_dur+1)/32 s. The longest pulse, at cfg_dur=63, is 2 s.
- R5: After reset, `lockout_o` is 1 for exactly LOCKOUT_SEC x 32 ticks (TICK_DIV clock cycles each) and then stays 0. A fire command issued while `lockout_o` is 1 is discarded. It starts no pulse, not even after the lockout ends, and it does not set `fire_err`.
- R6: At most one `act_out` bit is 1 at any time. A fire command issued while any channel is pending or driving is refused and sets `fire_err`. `fire_err` holds until `err_clr`. If a set and a clear fall in the same cycle, the set wins.
- R7: A channel's `armed_o` bit clears in the cycle its pulse ends. If an arm command for that channel arrives in that same cycle, the channel stays armed.
- R8: `fb_sync_o[i-1]` follows `fb_raw[i-1]` (status of channel i) through two register stages.
- R9: During and straight after reset, `act_out`, `armed_o`, `fire_err` and `fb_sync_o` are 0 and `lockout_o` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low synchronous reset |
| sec_count | input | SEC_W | Shared whole-seconds count |
| cfg_we | input | 1 | Load start second and length into channel `cfg_sel` |
| cfg_sel | input | SEL_W | Channel selected for configuration |
| cfg_time | input | SEC_W | Start second to load |
| cfg_dur | input | DUR_W | Pulse length code; length is code+1 units |
| arm_we | input | 1 | Arm channel `arm_sel` |
| arm_sel | input | SEL_W | Channel to arm |
| fire_we | input | 1 | Fire channel `fire_sel` |
| fire_sel | input | SEL_W | Channel to fire |
| err_clr | input | 1 | Clear the refused-fire flag |
| fb_raw | input | N_ACT-1 | Asynchronous status of channels 1..N_ACT-1 |
| act_out | output | N_ACT | Actuator switch drive, one bit per channel |
| armed_o | output | N_ACT | Armed state per channel |
| fire_err | output | 1 | A fire was refused because a channel was busy |
| lockout_o | output | 1 | Power-up lockout active |
| fb_sync_o | output | N_ACT-1 | Synchronized status of channels 1..N_ACT-1 |

## Verification
Two pairs of events can land in the same clock cycle. The first is the final tick of a running pulse, which both disarms the channel and frees the block. The second is a new command that needs the block to be idle. The bench measures the pulse width in cycles and uses it to present an arm for the finishing channel, together with a fire for another armed channel, in exactly the cycle the pulse ends. It then expects the finishing channel to stay armed, the fire to be refused with `fire_err` set, and no second pulse to follow. A separate step issues a refused fire and `err_clr` in the same cycle and expects the flag to end up set.

// File: rtl/act_pkg.sv
package act_pkg;
   // time base shared by all channels: 32 ticks per second
   localparam int TICKS_PER_SEC = 32;
   localparam int QTR_TICKS     = TICKS_PER_SEC / 4;

   function automatic int bits_for(input int n);
      return (n > 1) ? $clog2(n) : 1;
   endfunction
endpackage

// File: rtl/act_timebase.sv
module act_timebase
   import act_pkg::*;
#(
   parameter int TICK_DIV      = 524288,
   parameter int LOCKOUT_TICKS = 5760
) (
   input  logic clk,
   input  logic rst_n,
   output logic tick,
   output logic lockout
);
   localparam int PRE_W = bits_for(TICK_DIV);
   localparam int LK_W  = $clog2(LOCKOUT_TICKS + 1);

   generate
      if (TICK_DIV == 1) begin : g_div1
         assign tick = 1'b1;
      end else begin : g_divn
         logic [PRE_W-1:0] pre_q;
         assign tick = (pre_q == PRE_W'(TICK_DIV - 1));
         always_ff @(posedge clk) begin
            if (!rst_n)    pre_q <= '0;
            else if (tick) pre_q <= '0;
            else           pre_q <= pre_q + 1'b1;
         end
      end
   endgenerate

   logic [LK_W-1:0] lk_q;
   assign lockout = (lk_q != LK_W'(LOCKOUT_TICKS));

   always_ff @(posedge clk) begin
      if (!rst_n)                lk_q <= '0;
      else if (lockout && tick)  lk_q <= lk_q + 1'b1;
   end
endmodule

// File: rtl/act_chan.sv
module act_chan
   import act_pkg::*;
#(
   parameter int SEC_W      = 8,
   parameter int DUR_W      = 6,
   parameter int UNIT_TICKS = 1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             tick,
   input  logic [SEC_W-1:0] sec_now,
   input  logic             cfg_load,
   input  logic [SEC_W-1:0] cfg_time,
   input  logic [DUR_W-1:0] cfg_dur,
   input  logic             arm_set,
   input  logic             fire_go,
   output logic             armed,
   output logic             busy,
   output logic             drive
);
   localparam int MAX_LEN = (1 << DUR_W) * UNIT_TICKS;
   localparam int CNT_W   = bits_for(MAX_LEN);

   logic [SEC_W-1:0] time_q;
   logic [DUR_W-1:0] dur_q;
   logic [CNT_W-1:0] rem_q;
   logic             wait_q;
   logic             start, done;
   logic [CNT_W-1:0] load_len;

   assign start    = wait_q && tick && (sec_now == time_q);
   assign done     = drive && tick && (rem_q == '0);
   assign busy     = wait_q || drive;
   assign load_len = CNT_W'(dur_q) * CNT_W'(UNIT_TICKS) + CNT_W'(UNIT_TICKS - 1);

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         time_q <= '0;
         dur_q  <= '0;
      end else if (cfg_load) begin
         time_q <= cfg_time;
         dur_q  <= cfg_dur;
      end
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       armed <= 1'b0;
      else if (arm_set) armed <= 1'b1;
      else if (done)    armed <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)       wait_q <= 1'b0;
      else if (fire_go) wait_q <= 1'b1;
      else if (start)   wait_q <= 1'b0;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         drive <= 1'b0;
         rem_q <= '0;
      end else if (start) begin
         drive <= 1'b1;
         rem_q <= load_len;
      end else if (done) begin
         drive <= 1'b0;
      end else if (drive && tick) begin
         rem_q <= rem_q - 1'b1;
      end
   end
endmodule

// File: rtl/act_fb_sync.sv
module act_fb_sync #(
   parameter int WIDTH  = 3,
   parameter int STAGES = 2
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   logic [WIDTH-1:0] stg_q [STAGES];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         for (int k = 0; k < STAGES; k++) stg_q[k] <= '0;
      end else begin
         stg_q[0] <= d;
         for (int k = 1; k < STAGES; k++) stg_q[k] <= stg_q[k-1];
      end
   end

   assign q = stg_q[STAGES-1];
endmodule

// File: rtl/act_pulse_ctrl.sv
module act_pulse_ctrl
   import act_pkg::*;
#(
   parameter int N_ACT       = 4,
   parameter int SEC_W       = 8,
   parameter int DUR_W       = 6,
   parameter int TICK_DIV    = 524288,
   parameter int LOCKOUT_SEC = 180,
   parameter int SYNC_STAGES = 2,
   localparam int SEL_W      = bits_for(N_ACT)
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [SEC_W-1:0] sec_count,
   input  logic             cfg_we,
   input  logic [SEL_W-1:0] cfg_sel,
   input  logic [SEC_W-1:0] cfg_time,
   input  logic [DUR_W-1:0] cfg_dur,
   input  logic             arm_we,
   input  logic [SEL_W-1:0] arm_sel,
   input  logic             fire_we,
   input  logic [SEL_W-1:0] fire_sel,
   input  logic             err_clr,
   input  logic [N_ACT-2:0] fb_raw,
   output logic [N_ACT-1:0] act_out,
   output logic [N_ACT-1:0] armed_o,
   output logic             fire_err,
   output logic             lockout_o,
   output logic [N_ACT-2:0] fb_sync_o
);
   localparam int LOCKOUT_TICKS = LOCKOUT_SEC * TICKS_PER_SEC;

   initial begin
      if (N_ACT < 2)       $error("act_pulse_ctrl: N_ACT must be at least 2");
      if (DUR_W < 1)       $error("act_pulse_ctrl: DUR_W must be at least 1");
      if (TICK_DIV < 1)    $error("act_pulse_ctrl: TICK_DIV must be at least 1");
      if (LOCKOUT_SEC < 1) $error("act_pulse_ctrl: LOCKOUT_SEC must be at least 1");
      if (SYNC_STAGES < 2) $error("act_pulse_ctrl: SYNC_STAGES must be at least 2");
   end

   logic             tick, lockout;
   logic [N_ACT-1:0] busy;
   logic             busy_any;
   logic             refuse;

   act_timebase #(
      .TICK_DIV     (TICK_DIV),
      .LOCKOUT_TICKS(LOCKOUT_TICKS)
   ) u_tb (
      .clk    (clk),
      .rst_n  (rst_n),
      .tick   (tick),
      .lockout(lockout)
   );

   assign busy_any  = |busy;
   assign lockout_o = lockout;

   genvar i;
   generate
      for (i = 0; i < N_ACT; i++) begin : g_ch
         localparam int UNIT = (i == 0) ? QTR_TICKS : 1;
         logic cfg_hit, arm_hit, fire_hit;
         assign cfg_hit  = cfg_we  && (cfg_sel  == SEL_W'(i));
         assign arm_hit  = arm_we  && (arm_sel  == SEL_W'(i));
         assign fire_hit = fire_we && (fire_sel == SEL_W'(i)) &&
                           !lockout && !busy_any && armed_o[i];
         act_chan #(
            .SEC_W     (SEC_W),
            .DUR_W     (DUR_W),
            .UNIT_TICKS(UNIT)
         ) u_ch (
            .clk     (clk),
            .rst_n   (rst_n),
            .tick    (tick),
            .sec_now (sec_count),
            .cfg_load(cfg_hit),
            .cfg_time(cfg_time),
            .cfg_dur (cfg_dur),
            .arm_set (arm_hit),
            .fire_go (fire_hit),
            .armed   (armed_o[i]),
            .busy    (busy[i]),
            .drive   (act_out[i])
         );
      end
   endgenerate

   assign refuse = fire_we && !lockout && busy_any;

   always_ff @(posedge clk) begin
      if (!rst_n)       fire_err <= 1'b0;
      else if (refuse)  fire_err <= 1'b1;
      else if (err_clr) fire_err <= 1'b0;
   end

   act_fb_sync #(
      .WIDTH (N_ACT - 1),
      .STAGES(SYNC_STAGES)
   ) u_fb (
      .clk  (clk),
      .rst_n(rst_n),
      .d    (fb_raw),
      .q    (fb_sync_o)
   );
endmodule

// File: rtl/act_pulse_chk.sv
module act_pulse_chk #(
   parameter int N_ACT = 4
) (
   input logic             clk,
   input logic             rst_n,
   input logic [N_ACT-1:0] act_out,
   input logic [N_ACT-1:0] armed_o,
   input logic             fire_err,
   input logic             fire_we,
   input logic             lockout_o
);
   assert_single_drive_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0(act_out));

   assert_refuse_needs_cmd_R6: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(fire_err) |-> $past(fire_we));

   assert_quiet_in_lockout_R5: assert property (@(posedge clk) disable iff (!rst_n)
      lockout_o |-> (act_out == '0));

   assert_lockout_no_return_R5: assert property (@(posedge clk) disable iff (!rst_n)
      !$rose(lockout_o));

   assert_start_needs_arm_R1: assert property (@(posedge clk) disable iff (!rst_n)
      (act_out & ~$past(act_out) & ~$past(armed_o)) == '0);
endmodule

bind act_pulse_ctrl act_pulse_chk #(.N_ACT(N_ACT)) u_chk (
   .clk      (clk),
   .rst_n    (rst_n),
   .act_out  (act_out),
   .armed_o  (armed_o),
   .fire_err (fire_err),
   .fire_we  (fire_we),
   .lockout_o(lockout_o)
);

// File: tb/tb_act_pulse_ctrl.sv
module tb_act_pulse_ctrl;
   localparam int CLK_PERIOD = 10;
   localparam int N    = 4;
   localparam int SW   = 8;
   localparam int DW   = 6;
   localparam int DIV  = 4;
   localparam int LKS  = 2;
   localparam int LK_CYC = LKS * 32 * DIV;
   localparam int NV   = 7;
   // channel, duration code, expected width in cycles (ticks x DIV)
   localparam int VEC [NV][3] = '{
      '{0,  0,   32},
      '{0,  3,  128},
      '{0, 63, 2048},
      '{1,  0,    4},
      '{2, 63,  256},
      '{3,  5,   24},
      '{1, 31,  128}
   };

   logic          clk = 1'b0;
   logic          rst_n = 1'b0;
   logic [SW-1:0] sec_count = '0;
   logic          cfg_we = 1'b0;
   logic [1:0]    cfg_sel = '0;
   logic [SW-1:0] cfg_time = '0;
   logic [DW-1:0] cfg_dur = '0;
   logic          arm_we = 1'b0;
   logic [1:0]    arm_sel = '0;
   logic          fire_we = 1'b0;
   logic [1:0]    fire_sel = '0;
   logic          err_clr = 1'b0;
   logic [N-2:0]  fb_raw = '0;
   logic [N-1:0]  act_out, armed_o;
   logic          fire_err, lockout_o;
   logic [N-2:0]  fb_sync_o;

   int ncheck = 0, nfail = 0, cyc = 0;

   act_pulse_ctrl #(
      .N_ACT(N), .SEC_W(SW), .DUR_W(DW), .TICK_DIV(DIV), .LOCKOUT_SEC(LKS)
   ) dut (
      .clk(clk), .rst_n(rst_n), .sec_count(sec_count),
      .cfg_we(cfg_we), .cfg_sel(cfg_sel), .cfg_time(cfg_time), .cfg_dur(cfg_dur),
      .arm_we(arm_we), .arm_sel(arm_sel), .fire_we(fire_we), .fire_sel(fire_sel),
      .err_clr(err_clr), .fb_raw(fb_raw), .act_out(act_out), .armed_o(armed_o),
      .fire_err(fire_err), .lockout_o(lockout_o), .fb_sync_o(fb_sync_o)
   );

   always #(CLK_PERIOD/2) clk = ~clk;

   always @(posedge clk) begin
      if (!rst_n) cyc <= 0;
      else        cyc <= cyc + 1;
   end

   task automatic check(input string req, input int act, input int exp);
      ncheck++;
      if (act != exp) begin
         nfail++;
         $display("FAIL %s: got %0d expected %0d (t=%0t)", req, act, exp, $time);
      end
   endtask

   task automatic do_cfg(input int ch, input int t, input int d);
      @(negedge clk);
      cfg_we = 1'b1; cfg_sel = 2'(ch); cfg_time = SW'(t); cfg_dur = DW'(d);
      @(negedge clk);
      cfg_we = 1'b0;
   endtask

   task automatic do_arm(input int ch);
      @(negedge clk);
      arm_we = 1'b1; arm_sel = 2'(ch);
      @(negedge clk);
      arm_we = 1'b0;
   endtask

   task automatic do_fire(input int ch);
      @(negedge clk);
      fire_we = 1'b1; fire_sel = 2'(ch);
      @(negedge clk);
      fire_we = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(posedge clk);
      #1;
   endtask

   task automatic wait_rise(input int ch, input int lim, output int n);
      n = 0;
      while (!act_out[ch] && n < lim) begin
         @(posedge clk); #1; n++;
      end
   endtask

   task automatic width_of(input int ch, output int n);
      n = 0;
      while (act_out[ch] && n < 5000) begin
         @(posedge clk); #1; n++;
      end
   endtask

   task automatic finish_run();
      $display("== %0d vectors applied, %0d miscompares ==", ncheck, nfail);
      $finish;
   endtask

   initial begin
      #(CLK_PERIOD * 60000);
      nfail++;
      $display("FAIL watchdog: run did not complete");
      finish_run();
   end

   initial begin
      int n, w;
      repeat (3) @(negedge clk);
      // R9: state straight after reset
      check("R9 act_out", int'(act_out), 0);
      check("R9 armed_o", int'(armed_o), 0);
      check("R9 fire_err", int'(fire_err), 0);
      check("R9 lockout_o", int'(lockout_o), 1);
      check("R9 fb_sync_o", int'(fb_sync_o), 0);
      rst_n = 1'b1;

      // R5: fire during lockout is discarded
      do_cfg(1, 0, 0);
      do_arm(1);
      do_fire(1);
      idle(5 * DIV);
      check("R5 no pulse in lockout", int'(act_out), 0);
      check("R5 no error in lockout", int'(fire_err), 0);
      check("R1 arm sets armed_o", int'(armed_o[1]), 1);
      // R5: lockout length in cycles from reset release
      while (cyc != LK_CYC - 1) begin @(posedge clk); #1; end
      check("R5 lockout before end", int'(lockout_o), 1);
      @(posedge clk); #1;
      check("R5 lockout after end", int'(lockout_o), 0);
      idle(4 * DIV);
      check("R5 discarded fire stays dead", int'(act_out), 0);

      // R1: firing an unarmed channel
      do_cfg(2, 0, 0);
      do_fire(2);
      idle(5 * DIV);
      check("R1 unarmed fire no pulse", int'(act_out), 0);
      check("R1 unarmed fire no error", int'(fire_err), 0);

      // R3/R4: width table
      sec_count = 8'd3;
      for (int v = 0; v < NV; v++) begin
         do_cfg(VEC[v][0], 3, VEC[v][1]);
         do_arm(VEC[v][0]);
         do_fire(VEC[v][0]);
         wait_rise(VEC[v][0], 4 * DIV, n);
         width_of(VEC[v][0], w);
         if (VEC[v][0] == 0) check("R3 long width", w, VEC[v][2]);
         else                check("R4 short width", w, VEC[v][2]);
         check("R7 disarmed after pulse", int'(armed_o[VEC[v][0]]), 0);
      end

      // R2: start waits for sec_count match
      do_cfg(3, 7, 0);
      sec_count = 8'd6;
      do_arm(3);
      do_fire(3);
      idle(10 * DIV);
      check("R2 no start before match", int'(act_out), 0);
      @(negedge clk);
      sec_count = 8'd7;
      wait_rise(3, 4 * DIV, n);
      check("R2 start within one tick", int'(n <= DIV), 1);
      check("R2 pulse on match", int'(act_out[3]), 1);
      width_of(3, w);
      check("R4 matched pulse width", w, DIV);

      // R6: fire while busy is refused
      sec_count = 8'd9;
      do_cfg(0, 9, 10);
      do_cfg(1, 9, 0);
      do_arm(0);
      do_arm(1);
      do_fire(0);
      wait_rise(0, 4 * DIV, n);
      do_fire(1);
      check("R6 refused fire sets error", int'(fire_err), 1);
      width_of(0, w);
      idle(4 * DIV);
      check("R6 refused channel never pulses", int'(act_out), 0);
      check("R6 error holds", int'(fire_err), 1);
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      check("R6 err_clr clears", int'(fire_err), 0);

      // R7 + R6: arm and fire in the cycle a pulse ends
      do_cfg(2, 9, 3);
      do_arm(2);
      do_fire(2);
      wait_rise(2, 4 * DIV, n);
      repeat (4 * DIV - 1) @(posedge clk);
      @(negedge clk);
      arm_we = 1'b1; arm_sel = 2'd2;
      fire_we = 1'b1; fire_sel = 2'd1;
      @(posedge clk); #1;
      check("R7 pulse ended", int'(act_out[2]), 0);
      check("R7 arm wins over completion", int'(armed_o[2]), 1);
      check("R6 fire at completion refused", int'(fire_err), 1);
      @(negedge clk);
      arm_we = 1'b0; fire_we = 1'b0;
      idle(4 * DIV);
      check("R6 no pulse after refused fire", int'(act_out), 0);

      // R6: set and clear together, set wins
      do_fire(2);
      wait_rise(2, 4 * DIV, n);
      @(negedge clk); err_clr = 1'b1;
      @(negedge clk); err_clr = 1'b0;
      check("R6 clear while idle of error", int'(fire_err), 0);
      @(negedge clk);
      fire_we = 1'b1; fire_sel = 2'd1; err_clr = 1'b1;
      @(negedge clk);
      fire_we = 1'b0; err_clr = 1'b0;
      check("R6 set beats clear", int'(fire_err), 1);
      width_of(2, w);

      // R8: feedback synchronizer depth
      @(negedge clk);
      fb_raw = 3'b101;
      @(posedge clk); #1;
      check("R8 one stage not visible", int'(fb_sync_o), 0);
      @(posedge clk); #1;
      check("R8 two stages visible", int'(fb_sync_o), 5);

      finish_run();
   end
endmodule